// File: doc/BRIEF.md
# Paged Message-Object Data Window

This block gives a host access to the payload bytes of several message objects through two registers. A page register selects one object and one byte position inside that object's 8-byte buffer. A single data port then reads or writes the byte at that position. After each data-port access the byte position can step forward on its own, so a host can stream a whole payload through one address without rewriting the page.

The page register packs three fields. The object number sits in bits 7:4. An active-low step-disable flag sits in bit 3. The byte index sits in bits 2:0. A third register holds a 4-bit preset. Software can preload it with a flag-and-index pattern and then copy that pattern into the low nibble of the page register. Object numbers at or above the configured object count do not reach any storage. The storage has no reset value. The page and preset registers clear to zero on reset.

The bus is synchronous. `bus_rdata` always shows the register that `bus_addr` selects. State changes only on a clock edge where `bus_we` or `bus_re` is high. The address map is: 0 = page register, 1 = data port, 2 = preset register, 3 = unused.

Top module: `paged_obj_buffer`

## Requirements
- R1: After reset, the page register (address 0) and the preset register (address 2) both read 0x00.
- R2: A write to address 0 stores the full byte. The page register reads back as object number in bits 7:4, step-disable flag in bit 3, and byte index in bits 2:0.
- R3: `bus_rdata` at address 1 shows, without any strobe, the byte stored at the selected object and index. A write to address 1 stores `bus_wdata` at that object and index.
- R4: When bit 3 of the page register is 0, each clocked data-port access (read or write) adds one to the index. The index wraps from 7 to 0 and the object number is unchanged.
- R5: When bit 3 of the page register is 1, data-port accesses leave the whole page register unchanged.
- R6: When the selected object number is at or above NUM_OBJ (values up to 15), address 1 reads 0x00 and data-port writes change no stored byte. The index still follows R4 and R5.
- R7: Reads and writes at addresses 0, 2 and 3 never step the index. Only a write to address 0 changes the page register.
- R8: The preset register keeps bits 3:0 of the last value written to address 2 and reads back with bits 7:4 at zero. Address 3 reads 0x00 and ignores writes.
- R9: When `bus_we` and `bus_re` are both high in one cycle, the cycle counts as a single write. It stores one byte and steps the index at most once.
- R10: The objects are independent. A write to one object's byte leaves the same byte position of every other object unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register select (0 page, 1 data, 2 preset, 3 unused) |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; lets a data-port read step the index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |

## Verification
The bench uses the default parameters: six objects and a 2-bit address. Because the object field is 4 bits wide, numbers 6 through 15 can be written, so the out-of-range cases are reachable: both 6 (one past the last object) and 8 (top bit of the field set) are driven. With eight bytes per object, the index wraps from 7 to 0, and the bench checks that wrap on both a write and a following read.

// File: rtl/pob_pkg.sv
// Package: shared field widths, page register layout and bus address codes
// for the paged message-object data window.
// Assumes one byte per data-port access and an 8-bit page register.
package pob_pkg;
    localparam int OBJ_W   = 4;                 // object-number field width
    localparam int IDX_W   = 3;                 // byte-index field width
    localparam int BYTES   = 1 << IDX_W;        // bytes per object buffer
    localparam int DATA_W  = 8;                 // bus and byte width

    localparam int ADDR_PAGE   = 0;
    localparam int ADDR_DATA   = 1;
    localparam int ADDR_PRESET = 2;

    // Page register: object in 7:4, step-disable in 3, index in 2:0.
    typedef struct packed {
        logic [OBJ_W-1:0] obj;
        logic             hold_idx;
        logic [IDX_W-1:0] idx;
    } page_t;
endpackage

// File: rtl/pob_page_reg.sv
// Module: page and preset registers.
// Holds the selected object, the step-disable flag and the byte index, and
// advances the index after a data-port access when stepping is enabled.
// Assumes the caller never raises page_we and step in the same cycle
// (the top gives them disjoint address decodes).
module pob_page_reg
    import pob_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_we,
    input  logic [DATA_W-1:0]   page_wdata,
    input  logic                preset_we,
    input  logic [3:0]          preset_wdata,
    input  logic                step,
    output page_t               page_q,
    output logic [3:0]          preset_q
);
    page_t page_d;

    // Next page value: a host write wins, otherwise an optional index step.
    always_comb begin
        page_d = page_q;
        if (page_we) begin
            page_d = page_t'(page_wdata);
        end else if (step && !page_q.hold_idx) begin
            page_d.idx = page_q.idx + IDX_W'(1);
        end
    end

    // Page register flop with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) page_q <= '0;
        else        page_q <= page_d;
    end

    // Preset nibble flop with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         preset_q <= '0;
        else if (preset_we) preset_q <= preset_wdata;
    end
endmodule

// File: rtl/pob_byte_store.sv
// Module: byte storage for NUM_OBJ message objects of BYTES bytes each.
// One write port and one combinational read port, both addressed by
// object and index. Object numbers with no buffer match no slot: writes
// are dropped and the read returns zero with rd_valid low.
// Assumes 1 <= NUM_OBJ <= 2**OBJ_W. Storage has no reset value.
module pob_byte_store
    import pob_pkg::*;
#(
    parameter int NUM_OBJ = 6
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [OBJ_W-1:0]    wr_obj,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [OBJ_W-1:0]    rd_obj,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid
);
    logic [DATA_W-1:0] mem_q [NUM_OBJ][BYTES];
    logic [NUM_OBJ-1:0] rd_hit;
    logic [NUM_OBJ-1:0] wr_hit;

    // One match line per object for each port.
    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        assign rd_hit[g] = (rd_obj == OBJ_W'(g));
        assign wr_hit[g] = wr_en && (wr_obj == OBJ_W'(g));
    end

    assign rd_valid = |rd_hit;

    // Store the byte into the object whose match line is high.
    always_ff @(posedge clk) begin
        for (int o = 0; o < NUM_OBJ; o++) begin
            if (wr_hit[o]) mem_q[o][wr_idx] <= wr_data;
        end
    end

    // Select the addressed byte; zero when no object matches.
    always_comb begin
        rd_data = '0;
        for (int o = 0; o < NUM_OBJ; o++) begin
            if (rd_hit[o]) rd_data = mem_q[o][rd_idx];
        end
    end
endmodule

// File: rtl/paged_obj_buffer.sv
// Module: top of the paged message-object data window.
// Decodes the host bus into page, data-port and preset accesses, routes
// data-port traffic to the byte store at the paged object and index, and
// selects the read data. A cycle with both strobes high counts as a write.
// Assumes ADDR_W >= 2 and NUM_OBJ between 1 and 16.
module paged_obj_buffer
    import pob_pkg::*;
#(
    parameter int NUM_OBJ = 6,
    parameter int ADDR_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam logic [ADDR_W-1:0] A_PAGE   = ADDR_W'(ADDR_PAGE);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(ADDR_DATA);
    localparam logic [ADDR_W-1:0] A_PRESET = ADDR_W'(ADDR_PRESET);

    page_t             page_q;
    logic [3:0]        preset_q;
    logic              sel_page, sel_data, sel_preset;
    logic              data_access, data_write;
    logic [DATA_W-1:0] store_rdata;
    logic              store_valid;

    // Address decode and access qualification.
    always_comb begin
        sel_page    = (bus_addr == A_PAGE);
        sel_data    = (bus_addr == A_DATA);
        sel_preset  = (bus_addr == A_PRESET);
        data_access = sel_data && (bus_we || bus_re);
        data_write  = sel_data && bus_we;
    end

    pob_page_reg u_page (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_we      (bus_we && sel_page),
        .page_wdata   (bus_wdata),
        .preset_we    (bus_we && sel_preset),
        .preset_wdata (bus_wdata[3:0]),
        .step         (data_access),
        .page_q       (page_q),
        .preset_q     (preset_q)
    );

    pob_byte_store #(.NUM_OBJ(NUM_OBJ)) u_store (
        .clk      (clk),
        .wr_en    (data_write),
        .wr_obj   (page_q.obj),
        .wr_idx   (page_q.idx),
        .wr_data  (bus_wdata),
        .rd_obj   (page_q.obj),
        .rd_idx   (page_q.idx),
        .rd_data  (store_rdata),
        .rd_valid (store_valid)
    );

    // Read-data select for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (sel_page)                     bus_rdata = page_q;
        else if (sel_data && store_valid) bus_rdata = store_rdata;
        else if (sel_preset)              bus_rdata = {4'b0000, preset_q};
    end
endmodule

// File: rtl/paged_obj_buffer_chk.sv
// Module: property checker for paged_obj_buffer, bound to every instance.
// Observes the bus ports and the page register and checks the index
// stepping, page stability and out-of-range read rules.
module paged_obj_buffer_chk #(
    parameter int NUM_OBJ = 6,
    parameter int ADDR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        page_q
);
    logic at_page, at_data, acc;

    // Local decode of the bus for the properties.
    always_comb begin
        at_page = (bus_addr == ADDR_W'(0));
        at_data = (bus_addr == ADDR_W'(1));
        acc     = bus_we || bus_re;
    end

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && at_page) |=> (page_q == $past(bus_wdata)));  // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && at_data && !page_q[3]) |=> (page_q[2:0] == $past(page_q[2:0]) + 3'd1));  // R4
    AST_OBJ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && at_data) |=> (page_q[7:3] == $past(page_q[7:3])));  // R4
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && at_data && page_q[3]) |=> $stable(page_q));  // R5
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (at_data && int'(page_q[7:4]) >= NUM_OBJ) |-> (bus_rdata == 8'h00));  // R6
    AST_SIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !at_data && !(bus_we && at_page)) |=> $stable(page_q));  // R7
endmodule

bind paged_obj_buffer paged_obj_buffer_chk #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .page_q    (page_q)
);

// File: tb/tb_paged_obj_buffer.sv
// Bench: vector table walk followed by directed reset and corner tests.
module tb_paged_obj_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    paged_obj_buffer #(.NUM_OBJ(6), .ADDR_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    // Vector: {req[3:0], op[1:0], addr[1:0], wdata[7:0], expect[7:0]}
    // op 0 = write, 1 = strobed read (compare), 2 = peek without strobe (compare)
    localparam logic [23:0] VEC [23] = '{
        {4'd2, 2'd0, 2'd0, 8'h00, 8'h00},  // R2 obj0 idx0, stepping on
        {4'd3, 2'd0, 2'd1, 8'h11, 8'h00},  // R3
        {4'd3, 2'd0, 2'd1, 8'h22, 8'h00},  // R3
        {4'd3, 2'd0, 2'd1, 8'h33, 8'h00},  // R3
        {4'd4, 2'd2, 2'd0, 8'h00, 8'h03},  // R4 three steps
        {4'd2, 2'd0, 2'd0, 8'h10, 8'h00},  // obj1
        {4'd3, 2'd0, 2'd1, 8'h44, 8'h00},
        {4'd4, 2'd2, 2'd0, 8'h00, 8'h11},  // R4 object kept
        {4'd2, 2'd0, 2'd0, 8'h00, 8'h00},
        {4'd3, 2'd1, 2'd1, 8'h00, 8'h11},  // R3 readback
        {4'd3, 2'd1, 2'd1, 8'h00, 8'h22},
        {4'd3, 2'd1, 2'd1, 8'h00, 8'h33},
        {4'd4, 2'd2, 2'd0, 8'h00, 8'h03},  // R4 reads step too
        {4'd2, 2'd0, 2'd0, 8'h18, 8'h00},  // obj1, stepping off
        {4'd5, 2'd1, 2'd1, 8'h00, 8'h44},  // R5
        {4'd5, 2'd1, 2'd1, 8'h00, 8'h44},  // R5 same byte again
        {4'd5, 2'd2, 2'd0, 8'h00, 8'h18},  // R5 page unchanged
        {4'd2, 2'd0, 2'd0, 8'h07, 8'h00},  // obj0 idx7
        {4'd3, 2'd0, 2'd1, 8'h77, 8'h00},
        {4'd4, 2'd2, 2'd0, 8'h00, 8'h00},  // R4 wrap 7 -> 0
        {4'd3, 2'd2, 2'd1, 8'h00, 8'h11},  // R3 idx0 after wrap
        {4'd2, 2'd0, 2'd0, 8'h07, 8'h00},
        {4'd3, 2'd2, 2'd1, 8'h00, 8'h77}   // R3 idx7 stored
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b0; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        do_reset();
        // R1: reset state
        peek(2'd0, v); check("R1 page", v, 8'h00);
        peek(2'd2, v); check("R1 preset", v, 8'h00);

        for (int i = 0; i < 23; i++) begin
            logic [23:0] e;
            string tag;
            e = VEC[i];
            tag = $sformatf("R%0d vec%0d", e[23:20], i);
            case (e[19:18])
                2'd0: wr(e[17:16], e[15:8]);
                2'd1: begin rd(e[17:16], v); check(tag, v, e[7:0]); end
                default: begin peek(e[17:16], v); check(tag, v, e[7:0]); end
            endcase
        end

        // R2: full byte readback
        wr(2'd0, 8'h5B); peek(2'd0, v); check("R2 layout", v, 8'h5B);

        // R8: preset nibble, unused address
        wr(2'd2, 8'hA5); peek(2'd2, v); check("R8 preset", v, 8'h05);
        wr(2'd3, 8'hFF); peek(2'd3, v); check("R8 unused", v, 8'h00);
        peek(2'd0, v); check("R8 page untouched", v, 8'h5B);

        // R7: side-register accesses never step the index
        wr(2'd0, 8'h02);
        rd(2'd0, v); rd(2'd2, v); wr(2'd2, 8'h03);
        peek(2'd0, v); check("R7 no step", v, 8'h02);

        // R6: out-of-range objects
        wr(2'd0, 8'h05); wr(2'd1, 8'h5A);           // obj0 idx5 = 5A
        wr(2'd0, 8'h65); wr(2'd1, 8'hEE);           // obj6 idx5 write
        peek(2'd0, v); check("R6 index steps", v, 8'h66);
        wr(2'd0, 8'h65); peek(2'd1, v); check("R6 read zero", v, 8'h00);
        rd(2'd1, v); check("R6 strobed read zero", v, 8'h00);
        wr(2'd0, 8'h85); wr(2'd1, 8'hDD);           // obj8 (top bit set)
        peek(2'd1, v); check("R6 obj8 zero", v, 8'h00);
        wr(2'd0, 8'h05); peek(2'd1, v); check("R6 obj0 untouched", v, 8'h5A);
        for (int o = 1; o < 6; o++) begin
            wr(2'd0, {o[3:0], 4'h5}); wr(2'd1, 8'h50 + 8'(o));
        end
        wr(2'd0, 8'h05); peek(2'd1, v); check("R6 obj0 after", v, 8'h5A);

        // R10: independent objects at the same index
        wr(2'd0, 8'h24); wr(2'd1, 8'hC2);
        wr(2'd0, 8'h34); wr(2'd1, 8'hC3);
        wr(2'd0, 8'h54); wr(2'd1, 8'hC5);
        wr(2'd0, 8'h2C); peek(2'd1, v); check("R10 obj2", v, 8'hC2);
        wr(2'd0, 8'h3C); peek(2'd1, v); check("R10 obj3", v, 8'hC3);
        wr(2'd0, 8'h5C); peek(2'd1, v); check("R10 obj5", v, 8'hC5);

        // R9: both strobes in one cycle
        wr(2'd0, 8'h02);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h99; bus_we = 1'b1; bus_re = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_re = 1'b0;
        peek(2'd0, v); check("R9 single step", v, 8'h03);
        wr(2'd0, 8'h02); peek(2'd1, v2); check("R9 byte stored", v2, 8'h99);

        // R1: reset after activity
        do_reset();
        peek(2'd0, v); check("R1 page again", v, 8'h00);
        peek(2'd2, v); check("R1 preset again", v, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule